// File: doc/BRIEF.md
# Power Domain Controller Register Block

This block is the register face of a system power controller that sequences up to 64 power domains. A 32-bit register bus (write strobe, word address and write data, with combinational read data) reaches a controller-wide status word, per-group interrupt flag, enable and mask words, per-group summaries of settled domains, and, for each domain, a status, a power-up request, a power-down request and an error word.

Each domain holds a small state machine. An accepted request moves it into an in-progress state. It stays there for a parameterised number of cycles and then settles. On settling, the domain's interrupt flag is latched if its enable bit is set. The interrupt output is high while any flag is set, enabled and not masked. A request is refused while the controller is busy (two cycles after any accepted request) or while the addressed domain is still moving. A refused request sets the domain's error bit.

Top module: `pwr_dom_regs`

## Requirements
- R1: After reset every domain is off, the global word reads 3, the interrupt flag, enable and mask words read 0 and `irq` is low.
- R2: The global word at 0x000 reads 3 (bits 1:0 both set) when idle. It reads 0 for exactly the two cycles that follow the clock edge that accepts a request.
- R3: Domain n's status word sits at 0x1000 + 0x40*n and is one-hot: bit 0 off, bit 4 on, bit 8 power-down in progress, bit 12 power-up in progress.
- R4: Writing a word with bit 0 set to 0x1000 + 0x40*n + 4 requests power-up of domain n; the same at +8 requests power-down. A write with bit 0 clear has no effect.
- R5: A request is refused when the controller is busy or the domain is mid-transition. A refusal sets bit 0 of the error word at +0xC, and the next accepted request to that domain clears it.
- R6: The in-progress status is shown for TRANS_CYCLES cycles (default 8) after the accepting edge. The settled state appears on the next cycle.
- R7: Settled-on summaries are at 0x800 + 4*g and settled-off summaries at 0x808 + 4*g. Bit b of each stands for domain 32*g + b.
- R8: Completion sets bit b of the interrupt flag word at 0x810 + 4*g only when enable bit b at 0x820 + 4*g is set. Writing 1 to a flag bit clears it.
- R9: `irq` is high exactly while some flag bit is set, its enable bit is set and its mask bit (0x830 + 4*g) is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 16 | Byte address of a 32-bit word |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck busy counter shows in the global word one cycle after an accept. A second request sent two cycles later exposes it again, because its error bit sets when it should not (or the reverse). A transition counter that is off by one moves the edge between the in-progress and settled status by a cycle, so the reads just before and after cycle TRANS_CYCLES catch it at once. Wrong enable or clear handling of a flag shows in the flag word and on `irq` in the cycle after completion or after a mask write.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;
  localparam int MAX_DOMAINS = 64;
  localparam int DOM_W = 6;
  localparam int GRP_W = 1;
  localparam int GRP_SIZE = 32;

  typedef enum logic [3:0] {
    RS_NONE, RS_GSTAT, RS_PON, RS_POFF, RS_ISR, RS_IER, RS_IMR, RS_DSTAT, RS_DERR
  } rdSelT;

  typedef enum logic [1:0] {DS_OFF, DS_ON, DS_UP, DS_DOWN} domStateT;

  typedef struct packed {
    logic onReq;
    logic offReq;
    logic isrClr;
    logic ierWr;
    logic imrWr;
    logic [DOM_W-1:0] dom;
    logic [GRP_W-1:0] grp;
    rdSelT rdSel;
  } strobeT;
endpackage

// File: rtl/pwr_dom_decode.sv
module pwr_dom_decode
  import pwr_dom_pkg::*;
#(
  parameter int NUM_DOMAINS = 64
) (
  input  logic        wrEn,
  input  logic [15:0] addr,
  input  logic        wrBit0,
  output strobeT      strobes
);
  localparam int NUM_GROUPS = NUM_DOMAINS / GRP_SIZE;

  logic domOk;
  logic grpOk;

  assign domOk = ({1'b0, addr[11:6]} < 7'(NUM_DOMAINS));
  assign grpOk = (int'(addr[2]) < NUM_GROUPS);

  always_comb begin
    strobes = '0;
    strobes.rdSel = RS_NONE;
    strobes.dom = addr[11:6];
    strobes.grp = addr[2];
    if (addr[15:12] == 4'h1 && domOk) begin
      case (addr[5:0])
        6'h00: strobes.rdSel = RS_DSTAT;
        6'h04: strobes.onReq = wrEn & wrBit0;
        6'h08: strobes.offReq = wrEn & wrBit0;
        6'h0C: strobes.rdSel = RS_DERR;
        default: ;
      endcase
    end else if (addr[15:8] == 8'h08 && addr[1:0] == 2'b00 && grpOk) begin
      case (addr[7:3])
        5'h00: strobes.rdSel = RS_PON;
        5'h01: strobes.rdSel = RS_POFF;
        5'h02: begin strobes.rdSel = RS_ISR; strobes.isrClr = wrEn; end
        5'h04: begin strobes.rdSel = RS_IER; strobes.ierWr = wrEn; end
        5'h06: begin strobes.rdSel = RS_IMR; strobes.imrWr = wrEn; end
        default: ;
      endcase
    end else if (addr == 16'h0000) begin
      strobes.rdSel = RS_GSTAT;
    end
  end
endmodule

// File: rtl/pwr_dom_core.sv
module pwr_dom_core
  import pwr_dom_pkg::*;
#(
  parameter int NUM_DOMAINS = 64,
  parameter int TRANS_CYCLES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobeT                 strobes,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  output logic                   irq,
  output logic                   accepted,
  output logic                   busy,
  output logic [NUM_DOMAINS-1:0] ponV,
  output logic [NUM_DOMAINS-1:0] poffV,
  output logic [NUM_DOMAINS-1:0] isrV,
  output logic [NUM_DOMAINS-1:0] ierV,
  output logic [NUM_DOMAINS-1:0] imrV
);
  localparam int NUM_GROUPS = NUM_DOMAINS / GRP_SIZE;
  localparam int CNT_W = $clog2(TRANS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRANS_CYCLES - 1);

  logic [1:0]             busyCnt;
  logic [NUM_DOMAINS-1:0] upV, downV, doneV, errV, clrV;
  logic                   reqAny;
  logic                   inTrans;
  int                     grpIdx;
  int                     domIdx;

  assign domIdx  = int'(strobes.dom);
  assign grpIdx  = int'(strobes.grp);
  assign reqAny  = strobes.onReq | strobes.offReq;
  assign inTrans = upV[domIdx] | downV[domIdx];
  assign busy    = (busyCnt != 2'd0);
  assign accepted = reqAny & ~busy & ~inTrans;

  always_ff @(posedge clk) begin
    if (rst) busyCnt <= 2'd0;
    else if (accepted) busyCnt <= 2'd2;
    else if (busyCnt != 2'd0) busyCnt <= busyCnt - 2'd1;
  end

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    domStateT        state;
    logic [CNT_W-1:0] cnt;
    logic            hit;

    assign hit = reqAny && (domIdx == d);

    always_ff @(posedge clk) begin
      if (rst) begin
        state <= DS_OFF;
        cnt   <= '0;
        errV[d] <= 1'b0;
      end else begin
        if (hit) errV[d] <= ~accepted;
        if (hit && accepted) begin
          state <= strobes.onReq ? DS_UP : DS_DOWN;
          cnt   <= CNT_LOAD;
        end else if (state == DS_UP || state == DS_DOWN) begin
          if (cnt == '0) state <= (state == DS_UP) ? DS_ON : DS_OFF;
          else cnt <= cnt - 1'b1;
        end
      end
    end

    assign ponV[d]  = (state == DS_ON);
    assign poffV[d] = (state == DS_OFF);
    assign upV[d]   = (state == DS_UP);
    assign downV[d] = (state == DS_DOWN);
    assign doneV[d] = (upV[d] | downV[d]) && (cnt == '0);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign clrV[g*GRP_SIZE +: GRP_SIZE] = (strobes.isrClr && grpIdx == g) ? wrData : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        ierV[g*GRP_SIZE +: GRP_SIZE] <= '0;
        imrV[g*GRP_SIZE +: GRP_SIZE] <= '0;
      end else begin
        if (strobes.ierWr && grpIdx == g) ierV[g*GRP_SIZE +: GRP_SIZE] <= wrData;
        if (strobes.imrWr && grpIdx == g) imrV[g*GRP_SIZE +: GRP_SIZE] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) isrV <= '0;
    else isrV <= (isrV & ~clrV) | (doneV & ierV);
  end

  assign irq = |(isrV & ierV & ~imrV);

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      RS_GSTAT: rdData = {30'd0, busy ? 2'b00 : 2'b11};
      RS_PON:   rdData = ponV[grpIdx*GRP_SIZE +: GRP_SIZE];
      RS_POFF:  rdData = poffV[grpIdx*GRP_SIZE +: GRP_SIZE];
      RS_ISR:   rdData = isrV[grpIdx*GRP_SIZE +: GRP_SIZE];
      RS_IER:   rdData = ierV[grpIdx*GRP_SIZE +: GRP_SIZE];
      RS_IMR:   rdData = imrV[grpIdx*GRP_SIZE +: GRP_SIZE];
      RS_DSTAT: rdData = {19'd0, upV[domIdx], 3'd0, downV[domIdx], 3'd0,
                          ponV[domIdx], 3'd0, poffV[domIdx]};
      RS_DERR:  rdData = {31'd0, errV[domIdx]};
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/pwr_dom_regs.sv
module pwr_dom_regs
  import pwr_dom_pkg::*;
#(
  parameter int NUM_DOMAINS = 64,
  parameter int TRANS_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [15:0] addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq
);
  strobeT strobes;
  logic   accepted;
  logic   busy;
  logic [NUM_DOMAINS-1:0] ponV, poffV, isrV, ierV, imrV;

  pwr_dom_decode #(.NUM_DOMAINS(NUM_DOMAINS)) u_decode (
    .wrEn(wrEn), .addr(addr), .wrBit0(wrData[0]), .strobes(strobes)
  );

  pwr_dom_core #(.NUM_DOMAINS(NUM_DOMAINS), .TRANS_CYCLES(TRANS_CYCLES)) u_core (
    .clk(clk), .rst(rst), .strobes(strobes), .wrData(wrData),
    .rdData(rdData), .irq(irq), .accepted(accepted), .busy(busy),
    .ponV(ponV), .poffV(poffV), .isrV(isrV), .ierV(ierV), .imrV(imrV)
  );
endmodule

// File: rtl/pwr_dom_regs_chk.sv
module pwr_dom_regs_chk #(
  parameter int NUM_DOMAINS = 64
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   accepted,
  input logic                   busy,
  input logic [NUM_DOMAINS-1:0] ponV,
  input logic [NUM_DOMAINS-1:0] poffV,
  input logic [NUM_DOMAINS-1:0] isrV,
  input logic [NUM_DOMAINS-1:0] ierV,
  input logic [NUM_DOMAINS-1:0] imrV,
  input logic                   irq
);
  a_r1_reset_all_off: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (poffV == '1 && ponV == '0 && isrV == '0));

  a_r2_busy_two_cycles: assert property (@(posedge clk) disable iff (rst)
    accepted |=> busy ##1 busy ##1 !busy);

  a_r5_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accepted);

  a_r3_settled_exclusive: assert property (@(posedge clk) disable iff (rst)
    (ponV & poffV) == '0);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (isrV != '0 && ierV != '0));

  a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (imrV == '1) |-> !irq);
endmodule

bind pwr_dom_regs pwr_dom_regs_chk #(.NUM_DOMAINS(NUM_DOMAINS)) u_chk (
  .clk(clk), .rst(rst), .accepted(accepted), .busy(busy),
  .ponV(ponV), .poffV(poffV), .isrV(isrV), .ierV(ierV), .imrV(imrV), .irq(irq)
);

// File: tb/pwr_dom_regs_bench.sv
module pwr_dom_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } itemT;
  itemT q[$];

  always #2 clk = ~clk;

  pwr_dom_regs u_pwr_dom_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // monitor: compares queued expectations in the middle of the high phase
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        itemT it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.isIrq ? {31'd0, irq} : rdData;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  // all tasks start and end at a falling edge and take one cycle
  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    itemT it;
    addr = a; wrEn = 1'b0;
    it.isIrq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chkIrq(input logic e, input string tag);
    itemT it;
    it.isIrq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(16'h0000, 32'h3, "R1 global idle");
    rd(16'h1000, 32'h1, "R1 R3 dom0 off");
    rd(16'h0808, 32'hFFFF_FFFF, "R1 R7 off grp0");
    rd(16'h080C, 32'hFFFF_FFFF, "R1 R7 off grp1");
    rd(16'h0800, 32'h0, "R1 R7 on grp0");
    rd(16'h0810, 32'h0, "R1 flags");
    rd(16'h0820, 32'h0, "R1 enables");
    chkIrq(1'b0, "R1 irq low");

    // power-up domain 3 with its enable set
    wr(16'h0820, 32'h8);
    wr(16'h10C4, 32'h1);                           // accept at Ea
    rd(16'h0000, 32'h0, "R2 busy after accept");   // Na+1
    wr(16'h1144, 32'h1);                           // Na+2, still busy
    rd(16'h114C, 32'h1, "R5 refused while busy");  // Na+3
    rd(16'h10C0, 32'h1000, "R6 up in progress");   // Na+4
    rd(16'h0000, 32'h3, "R2 idle after two cycles"); // Na+5
    rd(16'h10C0, 32'h1000, "R6 up in progress");   // Na+6
    rd(16'h10C0, 32'h1000, "R6 last in-progress cycle"); // Na+7
    rd(16'h10C0, 32'h10, "R6 R3 settled on");      // Na+8
    rd(16'h0810, 32'h8, "R8 flag on completion");
    chkIrq(1'b1, "R9 irq raised");
    rd(16'h0800, 32'h8, "R7 on summary");
    rd(16'h0808, 32'hFFFF_FFF7, "R7 off summary");

    // mask and clear
    wr(16'h0830, 32'h8);
    chkIrq(1'b0, "R9 masked");
    wr(16'h0830, 32'h0);
    chkIrq(1'b1, "R9 unmasked");
    wr(16'h0810, 32'h8);
    rd(16'h0810, 32'h0, "R8 write-one clear");
    chkIrq(1'b0, "R9 irq after clear");

    // domain 5 retried, not enabled
    wr(16'h1144, 32'h1);
    rd(16'h114C, 32'h0, "R5 error cleared on accept");
    idle(8);
    rd(16'h1140, 32'h10, "R6 dom5 on");
    rd(16'h0810, 32'h0, "R8 no flag without enable");

    // power-down dom3, second request refused mid-transition
    wr(16'h10C8, 32'h1);                           // Nc
    idle(2);
    wr(16'h10C8, 32'h1);                           // Nc+3
    rd(16'h10CC, 32'h1, "R5 refused mid-transition");
    rd(16'h10C0, 32'h100, "R3 down in progress");  // Nc+5
    idle(2);
    rd(16'h10C0, 32'h1, "R3 settled off");         // Nc+8
    rd(16'h0810, 32'h8, "R8 flag after power-down");
    wr(16'h0810, 32'h8);

    // second group: domain 40
    wr(16'h0824, 32'h100);
    wr(16'h1A04, 32'h1);
    idle(8);
    rd(16'h0804, 32'h100, "R7 on summary grp1");
    rd(16'h080C, 32'hFFFF_FEFF, "R7 off summary grp1");
    rd(16'h0814, 32'h100, "R8 flag grp1");
    chkIrq(1'b1, "R9 irq grp1");

    // R4 write with bit 0 clear does nothing
    wr(16'h1004, 32'h2);
    rd(16'h0000, 32'h3, "R4 no request on bit0 clear");
    rd(16'h1000, 32'h1, "R4 dom0 still off");

    // accepted request clears the stale error of dom3
    wr(16'h10C8, 32'h1);
    rd(16'h10CC, 32'h0, "R5 error cleared");

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule